// File: doc/BRIEF.md
# Serial/Parallel Multiply-Accumulate Unit

The unit multiplies a parallel two's-complement coefficient by a bit-serial two's-complement data word and adds a serial addend. It returns the full-length result as a serial stream, least significant bit first. A word boundary is marked by a one-cycle start pulse that arrives with the data LSB. The coefficient is treated as a fraction with `COEF_W` fractional bits, so the addend enters at the weight of the data word. In integer terms, the addend is scaled by 2^COEF_W relative to the product.

A two-bit mode, sampled on the start pulse, sets where the addend comes from. Plain mode takes it from the serial addend input. Truncating-accumulate mode feeds back the upper `DATA_W` bits of the previous result as the addend. Full-precision mode does the same and also loads the low `COEF_W` result bits into the running sum before the first bit is formed, so that no part of the previous result is lost.

Each word occupies N = `DATA_W` + `COEF_W` cycles. During the extra cycles the data operand is sign-extended internally. Words may follow each other directly or be separated by idle cycles.

Top module: `sp_mac`

## Requirements
- R1: In plain mode (`mode_i` = 2'b00), the result is Y = a·X + Z·2^COEF_W mod 2^N. Here a, X and Z are two's complement and include the most negative coefficient.
- R2: `frame_i` marks the cycle that carries bit 0 of x and z. Result bit k appears on `y_o` one cycle after input cycle k. `y_first_o` is high with bit 0 only, and `y_valid_o` is high for exactly N consecutive cycles per word.
- R3: In truncating-accumulate mode (`mode_i` = 2'b01), Y = a·X + (Yprev with its low COEF_W bits cleared) mod 2^N. Yprev is the previous word's result, and `z_i` is ignored.
- R4: In full-precision mode (`mode_i[1]` = 1), Y = a·X + Yprev mod 2^N, and `z_i` is ignored.
- R5: `coef_i` and `mode_i` are sampled only in the `frame_i` cycle. Changes in later cycles of the word have no effect.
- R6: Only the first DATA_W cycles of `x_i` and `z_i` are used. The data is sign-extended from bit DATA_W-1, and input values in the remaining cycles have no effect.
- R7: After reset, `y_o`, `y_valid_o` and `y_first_o` are low, and Yprev is zero.
- R8: Yprev is held unchanged across any number of idle cycles between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Word start, coincides with operand LSB |
| mode_i | input | 2 | 00 plain, 01 truncating accumulate, 1x full precision |
| coef_i | input | COEF_W | Parallel two's-complement coefficient |
| x_i | input | 1 | Serial data operand, LSB first |
| z_i | input | 1 | Serial addend, LSB first (plain mode) |
| y_o | output | 1 | Serial result, LSB first |
| y_valid_o | output | 1 | Result bit valid |
| y_first_o | output | 1 | Result bit 0 marker |

## Verification
The assertions assume that `frame_i` is never raised while a word is still in progress. A new word may start at the earliest in the cycle after the last one. Under that assumption they check the word length, the range of the running sum and the hold of the result register while idle. The stimulus always drives a full N-cycle word before the next pulse and inserts 0 to 2 idle cycles between words. It fills the cycles that should be ignored with random values. Expected results are computed arithmetically from the previous expected result, so every accumulate chain is checked end to end.

// File: rtl/sp_mac_pkg.sv
package sp_mac_pkg;
  typedef enum logic [1:0] {
    MAC_PLAIN  = 2'b00,
    MAC_TRUNC  = 2'b01,
    MAC_FULL   = 2'b10,
    MAC_FULL_B = 2'b11
  } mac_mode_e;

  function automatic logic mode_full(input mac_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_fb(input mac_mode_e m);
    return m != MAC_PLAIN;
  endfunction
endpackage

// File: rtl/sp_mac_ctrl.sv
module sp_mac_ctrl
  import sp_mac_pkg::*;
#(
  parameter int COEF_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [1:0]        mode_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic              x_i,
  output logic              start_o,
  output logic              active_o,
  output logic              in_data_o,
  output mac_mode_e         mode_o,
  output logic [COEF_W-1:0] coef_o,
  output logic              x_bit_o,
  output logic              valid_o,
  output logic              first_o
);
  localparam int N  = COEF_W + DATA_W;
  localparam int CW = $clog2(N);
  localparam logic [CW-1:0] LAST   = CW'(N - 1);
  localparam logic [CW-1:0] D_LAST = CW'(DATA_W - 1);
  localparam logic [CW-1:0] D_LEN  = CW'(DATA_W);

  logic [CW-1:0]     cnt_q, phase;
  logic              busy_q, xs_q, valid_q, first_q;
  mac_mode_e         mode_q;
  logic [COEF_W-1:0] coef_q;

  assign start_o   = frame_i;
  assign active_o  = frame_i | busy_q;
  assign phase     = frame_i ? '0 : cnt_q;
  assign in_data_o = phase < D_LEN;
  assign mode_o    = frame_i ? mac_mode_e'(mode_i) : mode_q;
  assign coef_o    = frame_i ? coef_i : coef_q;
  assign x_bit_o   = in_data_o ? x_i : xs_q;   // sign extension past the data word
  assign valid_o   = valid_q;
  assign first_o   = first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      xs_q    <= 1'b0;
      mode_q  <= MAC_PLAIN;
      coef_q  <= '0;
      valid_q <= 1'b0;
      first_q <= 1'b0;
    end else begin
      valid_q <= active_o;
      first_q <= frame_i;
      if (frame_i) begin
        cnt_q  <= CW'(1);
        busy_q <= (N > 1);
        mode_q <= mac_mode_e'(mode_i);
        coef_q <= coef_i;
      end else if (busy_q) begin
        if (cnt_q == LAST) busy_q <= 1'b0;
        else               cnt_q  <= cnt_q + CW'(1);
      end
      if (active_o && phase == D_LAST) xs_q <= x_i;
    end
  end

  // input assumption: no new word while one is running
  assert_frame_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |-> !busy_q);

  assert_frame_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == LAST) |=> !busy_q);

  assert_first_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |-> valid_q);
endmodule

// File: rtl/sp_mac_dp.sv
module sp_mac_dp
  import sp_mac_pkg::*;
#(
  parameter int COEF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              active_i,
  input  logic              full_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic [COEF_W-1:0] preset_i,
  input  logic              x_bit_i,
  input  logic              z_bit_i,
  output logic              bit_o
);
  localparam int AW = COEF_W + 3;
  localparam int LO = -(1 << COEF_W);
  localparam int HI = 1 << (COEF_W + 1);

  logic signed [AW-1:0] acc_q, acc_cur, a_term, z_term, sum;

  // preset from saved low bits in full-precision mode, cleared otherwise
  assign acc_cur = start_i ? (full_i ? AW'({3'b000, preset_i}) : '0) : acc_q;
  // sign extension of the coefficient subtracts its top partial product
  assign a_term  = x_bit_i ? AW'({{3{coef_i[COEF_W-1]}}, coef_i}) : '0;
  assign z_term  = z_bit_i ? (AW'(1) <<< COEF_W) : '0;
  assign sum     = acc_cur + a_term + z_term;
  assign bit_o   = sum[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (active_i) acc_q <= sum >>> 1;
  end

  assert_acc_bounded_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(acc_q) >= LO) && (int'(acc_q) < HI));
endmodule

// File: rtl/sp_mac_result.sv
module sp_mac_result #(
  parameter int COEF_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              bit_i,
  output logic              y_o,
  output logic              fb_bit_o,
  output logic [COEF_W-1:0] low_o
);
  localparam int N = COEF_W + DATA_W;

  logic [N-1:0] y_sr;

  assign y_o      = y_sr[N-1];
  assign fb_bit_o = y_sr[COEF_W];
  assign low_o    = y_sr[COEF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       y_sr <= '0;
    else if (active_i) y_sr <= {bit_i, y_sr[N-1:1]};
  end

  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> $stable(y_sr));
endmodule

// File: rtl/sp_mac.sv
module sp_mac
  import sp_mac_pkg::*;
#(
  parameter int COEF_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [1:0]        mode_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic              x_i,
  input  logic              z_i,
  output logic              y_o,
  output logic              y_valid_o,
  output logic              y_first_o
);
  logic              start, active, in_data, x_bit, z_bit, fb_bit, prod_bit;
  mac_mode_e         mode;
  logic [COEF_W-1:0] coef, low;

  sp_mac_ctrl #(.COEF_W(COEF_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .frame_i, .mode_i, .coef_i, .x_i,
    .start_o(start), .active_o(active), .in_data_o(in_data),
    .mode_o(mode), .coef_o(coef), .x_bit_o(x_bit),
    .valid_o(y_valid_o), .first_o(y_first_o)
  );

  assign z_bit = in_data & (mode_fb(mode) ? fb_bit : z_i);

  sp_mac_dp #(.COEF_W(COEF_W)) u_dp (
    .clk_i, .rst_ni, .start_i(start), .active_i(active),
    .full_i(mode_full(mode)), .coef_i(coef), .preset_i(low),
    .x_bit_i(x_bit), .z_bit_i(z_bit), .bit_o(prod_bit)
  );

  sp_mac_result #(.COEF_W(COEF_W), .DATA_W(DATA_W)) u_res (
    .clk_i, .rst_ni, .active_i(active), .bit_i(prod_bit),
    .y_o, .fb_bit_o(fb_bit), .low_o(low)
  );

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(y_valid_o) |-> y_first_o);
endmodule

// File: tb/sp_mac_tb_top.sv
`timescale 1ns/1ps
module sp_mac_tb_top;
  localparam int WC = 4;
  localparam int WD = 5;
  localparam int N  = WC + WD;
  localparam longint MASK = (longint'(1) << N) - 1;
  localparam longint LOWM = (longint'(1) << WC) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          frame_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [WC-1:0] coef_i = '0;
  logic          x_i = 1'b0, z_i = 1'b0;
  logic          y_o, y_valid_o, y_first_o;

  int n_cmp = 0, n_bad = 0;
  longint y_model = 0;
  longint exp_q[$];
  string  tag_q[$];
  int     cap_cnt = 0;
  longint cap_word = 0;
  int     words_exp = 0, words_got = 0;

  sp_mac #(.COEF_W(WC), .DATA_W(WD)) dut_i (
    .clk_i, .rst_ni, .frame_i, .mode_i, .coef_i, .x_i, .z_i,
    .y_o, .y_valid_o, .y_first_o
  );

  always #4 clk_i = ~clk_i;

  function automatic longint sx(input longint v, input int w);
    longint r;
    r = v & ((longint'(1) << w) - 1);
    if ((r >> (w - 1)) & 1) r = r - (longint'(1) << w);
    return r;
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // monitor: collects one word per y_first_o, R2 framing checks
  always @(negedge clk_i) begin
    if (rst_ni && y_valid_o) begin
      if (y_first_o) begin
        if (cap_cnt != 0) check("R2 word length", cap_cnt, N);
        cap_cnt = 0;
        cap_word = 0;
      end
      cap_word = cap_word | (longint'(y_o) << cap_cnt);
      cap_cnt++;
      if (cap_cnt == N) begin
        words_got++;
        if (exp_q.size() == 0) check("R2 unexpected word", cap_word, -1);
        else check(tag_q.pop_front(), cap_word, exp_q.pop_front());
        cap_cnt = 0;
      end
    end else if (rst_ni && cap_cnt != 0) begin
      check("R2 valid gap", cap_cnt, N);
      cap_cnt = 0;
    end
  end

  task automatic run_frame(input logic [1:0] m, input longint a, input longint x,
                           input longint z, input int gap, input string tag);
    longint prod, y;
    prod = sx(a, WC) * sx(x, WD);
    if (m == 2'b00)      y = prod + (sx(z, WD) << WC);          // R1
    else if (m == 2'b01) y = prod + (y_model & ~LOWM);           // R3
    else                 y = prod + y_model;                     // R4
    y = y & MASK;
    y_model = y;
    exp_q.push_back(y);
    tag_q.push_back(tag);
    words_exp++;
    for (int k = 0; k < N; k++) begin
      @(negedge clk_i);
      frame_i = (k == 0);
      // R5: coefficient and mode scrambled after the start cycle
      coef_i  = (k == 0) ? WC'(a) : WC'($urandom);
      mode_i  = (k == 0) ? m : 2'($urandom);
      // R6: operand cycles beyond the data word carry garbage
      x_i     = (k < WD) ? x[k] : 1'($urandom);
      z_i     = (k < WD) ? z[k] : 1'($urandom);
    end
    for (int g = 0; g < gap; g++) begin   // R8: idle gap
      @(negedge clk_i);
      frame_i = 1'b0;
      coef_i  = WC'($urandom);
      mode_i  = 2'($urandom);
      x_i     = 1'($urandom);
      z_i     = 1'($urandom);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R7: reset state
    check("R7 y_o", y_o, 0);
    check("R7 y_valid_o", y_valid_o, 0);
    check("R7 y_first_o", y_first_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R7 idle valid", y_valid_o, 0);

    // R7: first full-precision word after reset starts from zero
    run_frame(2'b10, -3, 11, 9, 1, "R7 fresh accumulate");
    run_frame(2'b01, 5, -7, 0, 0, "R3 after R7");

    // R1: exhaustive coefficient and data sweep, selected addends
    for (int a = 0; a < (1 << WC); a++)
      for (int x = 0; x < (1 << WD); x++)
        for (int zi = 0; zi < 5; zi++) begin
          longint zv;
          case (zi)
            0: zv = 0;
            1: zv = 1;
            2: zv = -(1 << (WD - 1));
            3: zv = (1 << (WD - 1)) - 1;
            default: zv = -1;
          endcase
          run_frame(2'b00, a, x, zv, (a + x + zi) % 3, "R1 plain");
        end

    // R3/R4: random mixed accumulate chains, R5/R6/R8 exercised by driver
    for (int i = 0; i < 600; i++) begin
      logic [1:0] m;
      m = 2'($urandom);
      run_frame(m, $urandom, $urandom, $urandom, $urandom % 3,
                (m == 2'b00) ? "R1 mixed" : (m == 2'b01) ? "R3 mixed" : "R4 mixed");
    end

    // R4: long full-precision chain with extreme operands (wraps)
    for (int i = 0; i < 40; i++)
      run_frame(2'b11, -(1 << (WC - 1)), -(1 << (WD - 1)), 0, i % 2, "R4 extreme");
    // R3: truncating chain with extreme operands
    for (int i = 0; i < 40; i++)
      run_frame(2'b01, -(1 << (WC - 1)), (1 << (WD - 1)) - 1, 0, 0, "R3 extreme");

    @(negedge clk_i);
    frame_i = 1'b0;
    repeat (N + 3) @(negedge clk_i);
    check("R2 word count", words_got, words_exp);
    check("R2 pending", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule